// File: doc/BRIEF.md
# Reduced-pin PHY dibit to byte bridge

This block sits between a reduced-pin Ethernet PHY, which moves two bits per clock on each direction, and internal logic that works on whole bytes at half the PHY clock rate. The PHY side runs at 50 MHz and the byte side at 25 MHz, so the bridge owns two clock domains. All dibit handling happens on the fast side. Receive dibits are packed into bytes there, and transmit bytes are split into dibits there. Whole bytes, with their frame flags, cross between the domains through two small asynchronous FIFOs that use Gray-coded pointers and two-stage synchronisers.

On receive, every four dibits sampled while the carrier/data-valid input is high make one byte. The byte side sees each byte as a one-cycle `rx_valid` pulse. The first byte of a frame carries a start flag and the last complete byte carries an end flag. On transmit, the byte side writes bytes marked with start and end flags. The fast side sends each frame as one unbroken burst on `txd` with `tx_en` high. If the FIFO runs dry in the middle of a frame, the frame is cut off and an error pulse is raised. MAC framing, CRC and PHY management are handled elsewhere.

Top module: `rmii_byte_bridge`

## Requirements
- R1: After reset, `tx_en` is low, `txd` is 0, `tx_underrun` is low, `rx_valid` is low and `tx_ready` is high.
- R2: The first dibit sampled with `crs_dv` high becomes bits [1:0] of the first received byte, and the next three dibits fill [3:2], [5:4] and [7:6]. Every group of four dibits yields one `rx_data` byte, delivered on the byte side in arrival order as a one-cycle `rx_valid` pulse.
- R3: `rx_sof` is 1 on the first byte of a frame and `rx_eof` is 1 on the last complete byte, so a one-byte frame has both flags set. Both flags are 0 whenever `rx_valid` is 0.
- R4: Dibits sampled while `crs_dv` is low are ignored. If `crs_dv` falls after 1 to 3 dibits of an unfinished byte, those dibits are dropped. A burst shorter than four dibits produces no byte.
- R5: Each transmitted byte goes out on `txd` over four consecutive PHY cycles: bits [1:0] first, then [3:2], [5:4] and [7:6].
- R6: `tx_en` stays high without a gap from the first dibit of a frame's first byte to the last dibit of the byte written with `tx_eof`=1, so a frame of N bytes gives a burst of exactly 4N cycles. `txd` is 0 whenever `tx_en` is low.
- R7: A byte that reaches an idle transmitter with `tx_sof`=0 is discarded, and `tx_en` stays low.
- R8: If the next byte of an unfinished frame is missing when it is due, `tx_en` drops in that cycle and `tx_underrun` pulses high for one PHY cycle. The rest of that frame, up to and including its `tx_eof` byte, is then discarded.
- R9: `tx_ready` is low while the transmit FIFO is full, and a `tx_valid` strobe in a cycle with `tx_ready` low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phy_clk | input | 1 | 50 MHz PHY-side clock |
| phy_rst_n | input | 1 | Active-low asynchronous reset, PHY domain |
| byte_clk | input | 1 | 25 MHz byte-side clock |
| byte_rst_n | input | 1 | Active-low asynchronous reset, byte domain |
| rxd | input | 2 | Receive dibit from the PHY |
| crs_dv | input | 1 | Receive carrier / data valid from the PHY |
| txd | output | 2 | Transmit dibit to the PHY |
| tx_en | output | 1 | Transmit enable to the PHY |
| tx_underrun | output | 1 | One-cycle pulse when a frame is cut off for lack of data (PHY domain) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` holds a new byte this cycle |
| rx_sof | output | 1 | Received byte is the first of its frame |
| rx_eof | output | 1 | Received byte is the last of its frame |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Write strobe for `tx_data` |
| tx_sof | input | 1 | Byte to transmit starts a frame |
| tx_eof | input | 1 | Byte to transmit ends a frame |
| tx_ready | output | 1 | Transmit FIFO can accept a byte |

## Verification
A bad dibit counter or a bad shift register shows up within one byte as rotated or swapped bit pairs in `rx_data` or in the bytes rebuilt from `txd`. A wrong transmit state shows up as a `tx_en` burst whose length is not four times the byte count, as a gap inside a burst, or as a burst that never stops. A broken Gray pointer or flag path shows up as lost, repeated or junk bytes, or as misplaced start and end flags. It is visible at the first frame boundary, within a few byte clocks of that frame crossing the FIFO. The bench compares every byte and every burst length against values it builds from the frame index and byte index.

// File: rtl/rmii_byte_bridge.sv
`timescale 1ns/1ps
module rmii_byte_bridge #(
  parameter int AW = 3
) (
  input  logic       phy_clk,
  input  logic       phy_rst_n,
  input  logic       byte_clk,
  input  logic       byte_rst_n,
  input  logic [1:0] rxd,
  input  logic       crs_dv,
  output logic [1:0] txd,
  output logic       tx_en,
  output logic       tx_underrun,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_sof,
  output logic       rx_eof,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  input  logic       tx_sof,
  input  logic       tx_eof,
  output logic       tx_ready
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int WW    = 10;
  localparam logic [PW-1:0] PONE = 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic ptr_full(input logic [PW-1:0] wg, input logic [PW-1:0] rg);
    return wg == {~rg[PW-1:PW-2], rg[PW-3:0]};
  endfunction

  // receive assembly, PHY domain
  logic [5:0] acc;
  logic [1:0] dcnt;
  logic       first_q, pend_v, pend_sof;
  logic [7:0] pend_d;
  logic       rx_push;
  logic [WW-1:0] rx_word;

  assign rx_push = pend_v && (crs_dv ? (dcnt == 2'd3) : 1'b1);
  assign rx_word = {pend_sof, ~crs_dv, pend_d};

  always_ff @(posedge phy_clk or negedge phy_rst_n) begin
    if (!phy_rst_n) begin
      acc <= '0; dcnt <= '0; first_q <= 1'b1;
      pend_v <= 1'b0; pend_sof <= 1'b0; pend_d <= '0;
    end else if (crs_dv) begin
      acc  <= {rxd, acc[5:2]};
      dcnt <= dcnt + 2'd1;
      if (dcnt == 2'd3) begin
        pend_d   <= {rxd, acc};
        pend_v   <= 1'b1;
        pend_sof <= first_q;
        first_q  <= 1'b0;
      end
    end else begin
      dcnt    <= '0;
      first_q <= 1'b1;
      pend_v  <= 1'b0;
    end
  end

  // receive FIFO
  logic [WW-1:0] rxq [DEPTH];
  logic [PW-1:0] rxw_bin, rxw_gry, rxr_s1, rxr_s2;
  logic [PW-1:0] rxr_bin, rxr_gry, rxw_s1, rxw_s2;
  logic          rx_full, rx_empty;

  assign rx_full  = ptr_full(rxw_gry, rxr_s2);
  assign rx_empty = (rxr_gry == rxw_s2);

  always_ff @(posedge phy_clk) begin
    if (rx_push && !rx_full) rxq[rxw_bin[AW-1:0]] <= rx_word;
  end

  always_ff @(posedge phy_clk or negedge phy_rst_n) begin
    if (!phy_rst_n) begin
      rxw_bin <= '0; rxw_gry <= '0; rxr_s1 <= '0; rxr_s2 <= '0;
    end else begin
      rxr_s1 <= rxr_gry;
      rxr_s2 <= rxr_s1;
      if (rx_push && !rx_full) begin
        rxw_bin <= rxw_bin + PONE;
        rxw_gry <= to_gray(rxw_bin + PONE);
      end
    end
  end

  always_ff @(posedge byte_clk or negedge byte_rst_n) begin
    if (!byte_rst_n) begin
      rxr_bin <= '0; rxr_gry <= '0; rxw_s1 <= '0; rxw_s2 <= '0;
      rx_valid <= 1'b0; rx_sof <= 1'b0; rx_eof <= 1'b0; rx_data <= '0;
    end else begin
      rxw_s1   <= rxw_gry;
      rxw_s2   <= rxw_s1;
      rx_valid <= 1'b0;
      rx_sof   <= 1'b0;
      rx_eof   <= 1'b0;
      if (!rx_empty) begin
        {rx_sof, rx_eof, rx_data} <= rxq[rxr_bin[AW-1:0]];
        rx_valid <= 1'b1;
        rxr_bin  <= rxr_bin + PONE;
        rxr_gry  <= to_gray(rxr_bin + PONE);
      end
    end
  end

  // transmit FIFO
  logic [WW-1:0] txq [DEPTH];
  logic [PW-1:0] txw_bin, txw_gry, txr_s1, txr_s2;
  logic [PW-1:0] txr_bin, txr_gry, txw_s1, txw_s2;
  logic          tx_full, tx_empty, tx_wr, tx_pop;
  logic [WW-1:0] head;

  assign tx_full  = ptr_full(txw_gry, txr_s2);
  assign tx_ready = !tx_full;
  assign tx_wr    = tx_valid && !tx_full;
  assign tx_empty = (txr_gry == txw_s2);
  assign head     = txq[txr_bin[AW-1:0]];

  always_ff @(posedge byte_clk) begin
    if (tx_wr) txq[txw_bin[AW-1:0]] <= {tx_sof, tx_eof, tx_data};
  end

  always_ff @(posedge byte_clk or negedge byte_rst_n) begin
    if (!byte_rst_n) begin
      txw_bin <= '0; txw_gry <= '0; txr_s1 <= '0; txr_s2 <= '0;
    end else begin
      txr_s1 <= txr_gry;
      txr_s2 <= txr_s1;
      if (tx_wr) begin
        txw_bin <= txw_bin + PONE;
        txw_gry <= to_gray(txw_bin + PONE);
      end
    end
  end

  // transmit serialiser, PHY domain
  typedef enum logic [1:0] {T_IDLE, T_SEND, T_DROP} tx_st_t;
  tx_st_t     st;
  logic [5:0] tsh;
  logic [1:0] tcnt;
  logic       tlast;

  always_comb begin
    case (st)
      T_SEND:  tx_pop = (tcnt == 2'd0) && !tlast && !tx_empty;
      default: tx_pop = !tx_empty;
    endcase
  end

  always_ff @(posedge phy_clk or negedge phy_rst_n) begin
    if (!phy_rst_n) begin
      txr_bin <= '0; txr_gry <= '0; txw_s1 <= '0; txw_s2 <= '0;
    end else begin
      txw_s1 <= txw_gry;
      txw_s2 <= txw_s1;
      if (tx_pop) begin
        txr_bin <= txr_bin + PONE;
        txr_gry <= to_gray(txr_bin + PONE);
      end
    end
  end

  always_ff @(posedge phy_clk or negedge phy_rst_n) begin
    if (!phy_rst_n) begin
      st <= T_IDLE; tsh <= '0; tcnt <= '0; tlast <= 1'b0;
      txd <= '0; tx_en <= 1'b0; tx_underrun <= 1'b0;
    end else begin
      tx_underrun <= 1'b0;
      case (st)
        T_IDLE: begin
          if (!tx_empty && head[9]) begin
            txd <= head[1:0]; tx_en <= 1'b1; tsh <= head[7:2];
            tcnt <= 2'd1; tlast <= head[8]; st <= T_SEND;
          end
        end
        T_SEND: begin
          if (tcnt != 2'd0) begin
            txd  <= tsh[1:0];
            tsh  <= {2'b00, tsh[5:2]};
            tcnt <= tcnt + 2'd1;
          end else if (tlast) begin
            txd <= '0; tx_en <= 1'b0; st <= T_IDLE;
          end else if (!tx_empty) begin
            txd <= head[1:0]; tsh <= head[7:2];
            tcnt <= 2'd1; tlast <= head[8];
          end else begin
            txd <= '0; tx_en <= 1'b0; tx_underrun <= 1'b1; st <= T_DROP;
          end
        end
        default: begin
          if (!tx_empty && head[8]) st <= T_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rmii_byte_bridge_chk.sv
`timescale 1ns/1ps
module rmii_byte_bridge_chk (
  input logic       phy_clk,
  input logic       phy_rst_n,
  input logic       byte_clk,
  input logic       byte_rst_n,
  input logic [1:0] txd,
  input logic       tx_en,
  input logic       tx_underrun,
  input logic       rx_valid,
  input logic       rx_sof,
  input logic       rx_eof
);
  logic [1:0] run_mod;
  logic       rx_open;

  always_ff @(posedge phy_clk or negedge phy_rst_n) begin
    if (!phy_rst_n) run_mod <= '0;
    else if (tx_en) run_mod <= run_mod + 2'd1;
    else run_mod <= '0;
  end

  always_ff @(posedge byte_clk or negedge byte_rst_n) begin
    if (!byte_rst_n) rx_open <= 1'b0;
    else if (rx_valid) rx_open <= !rx_eof;
  end

  // R6
  tx_burst_len_chk: assert property (@(posedge phy_clk) disable iff (!phy_rst_n)
    $fell(tx_en) |-> run_mod == 2'd0);

  // R6
  txd_quiet_chk: assert property (@(posedge phy_clk) disable iff (!phy_rst_n)
    !tx_en |-> txd == 2'b00);

  // R8
  underrun_cut_chk: assert property (@(posedge phy_clk) disable iff (!phy_rst_n)
    tx_underrun |-> (!tx_en && $past(tx_en)));

  // R3
  rx_flag_idle_chk: assert property (@(posedge byte_clk) disable iff (!byte_rst_n)
    !rx_valid |-> (!rx_sof && !rx_eof));

  // R3
  rx_sof_order_chk: assert property (@(posedge byte_clk) disable iff (!byte_rst_n)
    (rx_valid && rx_sof) |-> !rx_open);

  // R3
  rx_body_order_chk: assert property (@(posedge byte_clk) disable iff (!byte_rst_n)
    (rx_valid && !rx_sof) |-> rx_open);
endmodule

bind rmii_byte_bridge rmii_byte_bridge_chk chk_i (
  .phy_clk(phy_clk), .phy_rst_n(phy_rst_n), .byte_clk(byte_clk), .byte_rst_n(byte_rst_n),
  .txd(txd), .tx_en(tx_en), .tx_underrun(tx_underrun),
  .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof)
);

// File: tb/rmii_byte_bridge_tb_top.sv
`timescale 1ns/1ps
module rmii_byte_bridge_tb_top;
  logic phy_clk = 1'b0, byte_clk = 1'b0;
  logic phy_rst_n = 1'b0, byte_rst_n = 1'b0;
  always #2.5 phy_clk = ~phy_clk;
  always #5 byte_clk = ~byte_clk;

  logic [1:0] rxd = '0, txd;
  logic crs_dv = 1'b0, tx_en, tx_underrun;
  logic [7:0] rx_data, tx_data = '0;
  logic rx_valid, rx_sof, rx_eof, tx_ready;
  logic tx_valid = 1'b0, tx_sof = 1'b0, tx_eof = 1'b0;

  rmii_byte_bridge dut_i (
    .phy_clk(phy_clk), .phy_rst_n(phy_rst_n), .byte_clk(byte_clk), .byte_rst_n(byte_rst_n),
    .rxd(rxd), .crs_dv(crs_dv), .txd(txd), .tx_en(tx_en), .tx_underrun(tx_underrun),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .tx_ready(tx_ready)
  );

  int checks = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'((f * 37 + i * 11 + 5) & 255);
  endfunction

  // receive capture
  logic [9:0] rx_got [0:1023];
  logic [9:0] rx_exp [0:1023];
  int rx_n = 0, rx_en_n = 0;
  always @(negedge byte_clk) if (rx_valid) begin
    if (rx_n < 1024) rx_got[rx_n] = {rx_sof, rx_eof, rx_data};
    rx_n++;
  end

  // transmit capture
  logic [7:0] tx_acc = '0;
  logic [7:0] tx_got [0:1023];
  logic [7:0] tx_exp [0:1023];
  int tx_runs [0:63];
  int run_exp [0:63];
  int tx_bn = 0, tx_en_n = 0, tx_rn = 0, re_n = 0, dib = 0, run = 0, und_n = 0, quiet_bad = 0;
  always @(negedge phy_clk) begin
    if (tx_underrun) und_n++;
    if (!tx_en && txd != 2'b00) quiet_bad++;
    if (tx_en) begin
      tx_acc = {txd, tx_acc[7:2]};
      dib++; run++;
      if (dib == 4) begin
        if (tx_bn < 1024) tx_got[tx_bn] = tx_acc;
        tx_bn++; dib = 0;
      end
    end else begin
      if (run != 0) begin
        if (tx_rn < 64) tx_runs[tx_rn] = run;
        tx_rn++; run = 0;
      end
      dib = 0;
    end
  end

  task automatic rx_frame(input int f, input int len, input int tail);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = pat(f, i);
      for (int k = 0; k < 4; k++) begin
        @(negedge phy_clk); crs_dv = 1'b1; rxd = b[2*k +: 2];
      end
      rx_exp[rx_en_n] = {(i == 0), (i == len - 1), b};
      rx_en_n++;
    end
    for (int t = 0; t < tail; t++) begin
      @(negedge phy_clk); crs_dv = 1'b1; rxd = 2'(t + 1);
    end
    for (int g = 0; g < 10; g++) begin
      @(negedge phy_clk); crs_dv = 1'b0; rxd = 2'b11;
    end
  endtask

  task automatic tx_put(input logic [7:0] d, input logic s, input logic e);
    @(negedge byte_clk);
    while (!tx_ready) @(negedge byte_clk);
    tx_valid = 1'b1; tx_data = d; tx_sof = s; tx_eof = e;
    @(negedge byte_clk); tx_valid = 1'b0;
  endtask

  task automatic tx_frame(input int f, input int len, input bit pushy);
    int i = 0;
    while (i < len) begin
      @(negedge byte_clk);
      if (tx_ready) begin
        tx_valid = 1'b1; tx_data = pat(f, i); tx_sof = (i == 0); tx_eof = (i == len - 1);
        tx_exp[tx_en_n] = pat(f, i); tx_en_n++;
        i++;
      end else if (pushy) begin
        tx_valid = 1'b1; tx_data = 8'hEE; tx_sof = 1'b1; tx_eof = 1'b1;
      end else tx_valid = 1'b0;
    end
    @(negedge byte_clk); tx_valid = 1'b0;
    run_exp[re_n] = 4 * len; re_n++;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge phy_clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog R1..R9 actual=hang expected=finish");
      finish_run();
    end
  end

  initial begin
    int rn0, bn0;
    repeat (4) @(negedge byte_clk);
    phy_rst_n = 1'b1; byte_rst_n = 1'b1;
    @(negedge byte_clk);
    // R1
    chk(!tx_en, "R1 tx_en", tx_en, 0);
    chk(txd == 0, "R1 txd", txd, 0);
    chk(!tx_underrun, "R1 tx_underrun", tx_underrun, 0);
    chk(!rx_valid, "R1 rx_valid", rx_valid, 0);
    chk(tx_ready, "R1 tx_ready", tx_ready, 1);

    // receive: several lengths, trailing partial dibits, a dibit-only burst
    rx_frame(1, 1, 0);
    rx_frame(2, 2, 3);
    rx_frame(3, 0, 3);
    rx_frame(4, 5, 1);
    rx_frame(5, 3, 2);
    rx_frame(6, 256, 0);
    rx_frame(7, 7, 0);
    rxd = 2'b00;
    repeat (40) @(negedge byte_clk);
    // R4: partial bytes and idle dibits add no bytes
    chk(rx_n == rx_en_n, "R4 rx byte count", rx_n, rx_en_n);
    for (int i = 0; i < rx_en_n && i < rx_n; i++) begin
      // R2
      chk(rx_got[i][7:0] == rx_exp[i][7:0], "R2 rx byte", rx_got[i][7:0], rx_exp[i][7:0]);
      // R3
      chk(rx_got[i][9:8] == rx_exp[i][9:8], "R3 rx flags", rx_got[i][9:8], rx_exp[i][9:8]);
    end

    // transmit: back-to-back frames
    tx_frame(10, 1, 0);
    tx_frame(11, 2, 0);
    tx_frame(12, 3, 0);
    tx_frame(13, 5, 0);
    tx_frame(14, 8, 0);
    // R9: strobes while full carry junk that must not appear
    tx_frame(15, 40, 1);
    repeat (120) @(negedge byte_clk);

    // R7: lone byte without start flag
    rn0 = tx_rn; bn0 = tx_bn;
    tx_put(8'h5A, 1'b0, 1'b1);
    repeat (30) @(negedge byte_clk);
    chk(tx_rn == rn0 && !tx_en, "R7 no burst", tx_rn, rn0);
    chk(tx_bn == bn0, "R7 no bytes", tx_bn, bn0);

    // R8: underrun after two bytes, rest of frame discarded
    tx_put(pat(20, 0), 1'b1, 1'b0);
    tx_put(pat(20, 1), 1'b0, 1'b0);
    tx_exp[tx_en_n] = pat(20, 0); tx_en_n++;
    tx_exp[tx_en_n] = pat(20, 1); tx_en_n++;
    run_exp[re_n] = 8; re_n++;
    repeat (50) @(negedge byte_clk);
    chk(und_n == 1, "R8 underrun pulses", und_n, 1);
    tx_put(pat(20, 2), 1'b0, 1'b0);
    tx_put(pat(20, 3), 1'b1, 1'b1);
    repeat (30) @(negedge byte_clk);
    chk(tx_rn == re_n, "R8 dropped tail", tx_rn, re_n);
    tx_frame(21, 4, 0);
    repeat (60) @(negedge byte_clk);

    chk(und_n == 1, "R8 single underrun", und_n, 1);
    chk(tx_bn == tx_en_n, "R5 tx byte count", tx_bn, tx_en_n);
    for (int i = 0; i < tx_en_n && i < tx_bn; i++)
      chk(tx_got[i] == tx_exp[i], "R5 tx byte", tx_got[i], tx_exp[i]);
    chk(tx_rn == re_n, "R6 burst count", tx_rn, re_n);
    for (int i = 0; i < re_n && i < tx_rn && i < 64; i++)
      chk(tx_runs[i] == run_exp[i], "R6 burst length", tx_runs[i], run_exp[i]);
    chk(quiet_bad == 0, "R6 txd idle", quiet_bad, 0);
    chk(tx_ready, "R9 ready after drain", tx_ready, 1);
    finish_run();
  end
endmodule